// File: doc/BRIEF.md
# Pipelined Two-Stage Table Lookup

This block resolves a key into a result through two chained memory tables. The key indexes a large first table. The word read from that table is used directly as the index into a smaller second table, and the word read there is the result. A register sits at every boundary along the chain, so each clock period contains at most one memory read. Keys can be issued on every cycle. Results return in issue order after a fixed delay of five cycles, and no stall condition exists.

Each table has its own loading port, made up of an enable, a write strobe, an address and data. A load goes through only when the enable and the strobe are both high. Loads may be mixed with lookups at any time. On a same-address collision the table behaves read-first. The key width is a parameter and can be set as wide as 17 bits for a 128K-entry first table. The default is a smaller first table, which keeps elaboration light. The width of the first table's data is, by construction, the same as the address width of the second table.

Top module: `cascade_lookup`

## Requirements
- R1: When a key is accepted, `res_o` carries the second-table word stored at the address equal to the first-table word stored at the key.
- R2: `res_valid_o` rises exactly five clock cycles after `key_valid_i` was sampled high. A key may be issued on every cycle, and results come out in the order the keys went in.
- R3: A table is written on a rising clock edge only when its enable and its write strobe are both high. With either one low, the table contents do not change.
- R4: When a write and a lookup read reach the same table address on the same clock edge, the lookup returns the contents from before the write. The first table is read on the second edge after the key is accepted. The second table is read on the fourth edge.
- R5: The active-low reset `rst_ni` forces `res_valid_o` low at once and discards any lookups still in flight. It leaves the contents of both tables unchanged.
- R6: While `res_valid_o` is low, `res_o` keeps the most recent result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | Key qualifier |
| key_i | input | KEY_W | Lookup key |
| res_valid_o | output | 1 | Result qualifier |
| res_o | output | RES_W | Lookup result |
| a_en_i | input | 1 | First-table load enable |
| a_we_i | input | 1 | First-table write strobe |
| a_addr_i | input | KEY_W | First-table load address |
| a_data_i | input | MID_W | First-table load data |
| b_en_i | input | 1 | Second-table load enable |
| b_we_i | input | 1 | Second-table write strobe |
| b_addr_i | input | MID_W | Second-table load address |
| b_data_i | input | RES_W | Second-table load data |

## Verification
The case that is hardest to create from the ports is a write that collides with the read of a lookup already in flight. Such a write has to arrive exactly one cycle after the key for the first table and exactly three cycles after the key for the second table. The stimulus issues a single isolated key, then times a load to the matching address at that offset and confirms that the old word comes back. A later lookup of the same key confirms that the new word took effect. A reset applied while keys are still in the pipeline also checks that none of those keys produce an output, and that the table contents outlive the reset.

// File: rtl/cascade_lookup_pkg.sv
package cascade_lookup_pkg;
  localparam int unsigned DEF_KEY_W = 11;
  localparam int unsigned DEF_MID_W = 10;
  localparam int unsigned DEF_RES_W = 6;
  localparam int unsigned LATENCY   = 5;
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // read-first: the read register samples the array before the write lands
  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_we_i) mem[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  p_wr_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_we_i) |=> mem[$past(wr_addr_i)] == $past(wr_data_i));

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  output logic          v_o,
  output logic [DW-1:0] d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_o <= 1'b0;
    else         v_o <= v_i;
  end

  // data loads only with a valid beat, so bubbles leave it unchanged
  always_ff @(posedge clk_i) begin
    if (v_i && rst_ni) d_o <= d_i;
  end
endmodule

// File: rtl/cascade_lookup.sv
module cascade_lookup
  import cascade_lookup_pkg::*;
#(
  parameter int unsigned KEY_W = DEF_KEY_W,
  parameter int unsigned MID_W = DEF_MID_W,
  parameter int unsigned RES_W = DEF_RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_o,
  input  logic             a_en_i,
  input  logic             a_we_i,
  input  logic [KEY_W-1:0] a_addr_i,
  input  logic [MID_W-1:0] a_data_i,
  input  logic             b_en_i,
  input  logic             b_we_i,
  input  logic [MID_W-1:0] b_addr_i,
  input  logic [RES_W-1:0] b_data_i
);
  logic             v1, v2, v3, v4;
  logic [KEY_W-1:0] key_q;
  logic [MID_W-1:0] a_rd, mid_q;
  logic [RES_W-1:0] b_rd;

  stage_reg #(.DW(KEY_W)) u_key (
    .clk_i, .rst_ni, .v_i(key_valid_i), .d_i(key_i), .v_o(v1), .d_o(key_q)
  );

  lut_table #(.AW(KEY_W), .DW(MID_W)) u_tab_a (
    .clk_i, .rst_ni,
    .wr_en_i(a_en_i), .wr_we_i(a_we_i), .wr_addr_i(a_addr_i), .wr_data_i(a_data_i),
    .rd_en_i(v1), .rd_addr_i(key_q), .rd_data_o(a_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0;
      v4 <= 1'b0;
    end else begin
      v2 <= v1;
      v4 <= v3;
    end
  end

  stage_reg #(.DW(MID_W)) u_mid (
    .clk_i, .rst_ni, .v_i(v2), .d_i(a_rd), .v_o(v3), .d_o(mid_q)
  );

  lut_table #(.AW(MID_W), .DW(RES_W)) u_tab_b (
    .clk_i, .rst_ni,
    .wr_en_i(b_en_i), .wr_we_i(b_we_i), .wr_addr_i(b_addr_i), .wr_data_i(b_data_i),
    .rd_en_i(v3), .rd_addr_i(mid_q), .rd_data_o(b_rd)
  );

  stage_reg #(.DW(RES_W)) u_res (
    .clk_i, .rst_ni, .v_i(v4), .d_i(b_rd), .v_o(res_valid_o), .d_o(res_o)
  );

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(key_valid_i, LATENCY));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> res_valid_o);

  p_rst_flush_r5: assert property (@(posedge clk_i)
    !rst_ni |=> !res_valid_o);
endmodule

// File: tb/cascade_lookup_tb_top.sv
module cascade_lookup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 11;
  localparam int MW = 10;
  localparam int RW = 6;

  typedef struct packed {
    logic          aen, awe;
    logic [KW-1:0] aa;
    logic [MW-1:0] ad;
    logic          ben, bwe;
    logic [MW-1:0] ba;
    logic [RW-1:0] bd;
  } wr_t;

  localparam wr_t IDLE = '0;
  localparam logic [KW-1:0] VEC_KEYS [16] = '{
    11'd0, 11'd2047, 11'd1, 11'd1024, 11'd1023, 11'd5, 11'd5, 11'd77,
    11'd1500, 11'd256, 11'd0, 11'd2046, 11'd999, 11'd3, 11'd1234, 11'd640
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic key_valid_i = 1'b0;
  logic [KW-1:0] key_i = '0;
  logic res_valid_o;
  logic [RW-1:0] res_o;
  logic a_en_i = 0, a_we_i = 0, b_en_i = 0, b_we_i = 0;
  logic [KW-1:0] a_addr_i = '0;
  logic [MW-1:0] a_data_i = '0, b_addr_i = '0;
  logic [RW-1:0] b_data_i = '0;

  cascade_lookup #(.KEY_W(KW), .MID_W(MW), .RES_W(RW)) dut_i (
    .clk_i(clk), .rst_ni, .key_valid_i, .key_i, .res_valid_o, .res_o,
    .a_en_i, .a_we_i, .a_addr_i, .a_data_i,
    .b_en_i, .b_we_i, .b_addr_i, .b_data_i
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [MW-1:0] ref_a [1<<KW];
  logic [RW-1:0] ref_b [1<<MW];
  bit            pv_v [6];
  logic [RW-1:0] pv_d [6];
  string         pv_tag [6];
  logic [RW-1:0] last_res;
  bit            have_res = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  function automatic logic [MW-1:0] pat_a(int i);
    return MW'((i * 37 + 5) % (1 << MW));
  endfunction

  function automatic logic [RW-1:0] pat_b(int x);
    return RW'((x * 13) ^ (x >> 3));
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit kv, logic [KW-1:0] k, wr_t w, string tag);
    @(negedge clk);
    for (int s = 5; s > 0; s--) begin
      pv_v[s] = pv_v[s-1]; pv_d[s] = pv_d[s-1]; pv_tag[s] = pv_tag[s-1];
    end
    pv_v[0] = kv; pv_tag[0] = tag;
    pv_d[0] = kv ? ref_b[ref_a[k]] : '0;
    if (w.aen && w.awe) ref_a[w.aa] = w.ad;
    if (w.ben && w.bwe) ref_b[w.ba] = w.bd;
    key_valid_i = kv; key_i = k;
    a_en_i = w.aen; a_we_i = w.awe; a_addr_i = w.aa; a_data_i = w.ad;
    b_en_i = w.ben; b_we_i = w.bwe; b_addr_i = w.ba; b_data_i = w.bd;
    check("R2", "res_valid_o", 32'(res_valid_o), 32'(pv_v[5]));
    if (pv_v[5]) begin
      check(pv_tag[5], "res_o", 32'(res_o), 32'(pv_d[5]));
      last_res = pv_d[5]; have_res = 1;
    end else if (have_res) begin
      check("R6", "res_o hold", 32'(res_o), 32'(last_res));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, IDLE, "");
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_ni = 0; key_valid_i = 0;
    for (int s = 0; s < 6; s++) pv_v[s] = 0;
    #1 check("R5", "res_valid_o in reset", 32'(res_valid_o), 32'd0);
    for (int i = 0; i < n; i++) @(negedge clk);
    check("R5", "res_valid_o held in reset", 32'(res_valid_o), 32'd0);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wr_t w;
    for (int s = 0; s < 6; s++) begin pv_v[s] = 0; pv_d[s] = '0; pv_tag[s] = ""; end
    do_reset(3);
    // load both tables
    for (int i = 0; i < (1 << KW); i++) begin
      w = IDLE; w.aen = 1; w.awe = 1; w.aa = KW'(i); w.ad = pat_a(i);
      step(0, '0, w, "");
    end
    for (int i = 0; i < (1 << MW); i++) begin
      w = IDLE; w.ben = 1; w.bwe = 1; w.ba = MW'(i); w.bd = pat_b(i);
      step(0, '0, w, "");
    end
    idle(5);
    // R1: directed key vectors, back to back
    for (int i = 0; i < 16; i++) step(1, VEC_KEYS[i], IDLE, "R1");
    idle(6);
    // R2: random stream with bubbles
    for (int i = 0; i < 400; i++) begin
      logic [KW-1:0] rk;
      rk = KW'($urandom());
      step(($urandom() % 4) != 0, rk, IDLE, "R2");
    end
    idle(6);
    // R3: partial write controls must not change contents
    w = IDLE; w.aen = 1; w.awe = 0; w.aa = 11'd100; w.ad = ~ref_a[100];
    step(0, '0, w, "");
    w = IDLE; w.aen = 0; w.awe = 1; w.aa = 11'd100; w.ad = ~ref_a[100];
    step(0, '0, w, "");
    w = IDLE; w.ben = 1; w.bwe = 0; w.ba = ref_a[100]; w.bd = ~ref_b[ref_a[100]];
    step(0, '0, w, "");
    w = IDLE; w.ben = 0; w.bwe = 1; w.ba = ref_a[100]; w.bd = ~ref_b[ref_a[100]];
    step(0, '0, w, "");
    step(1, 11'd100, IDLE, "R3");
    idle(6);
    // R4: first-table collision, write one cycle after the key
    step(1, 11'd200, IDLE, "R4");
    w = IDLE; w.aen = 1; w.awe = 1; w.aa = 11'd200; w.ad = ref_a[200] ^ 10'h155;
    step(0, '0, w, "");
    idle(5);
    step(1, 11'd200, IDLE, "R4");
    idle(6);
    // R4: second-table collision, write three cycles after the key
    step(1, 11'd300, IDLE, "R4");
    idle(2);
    w = IDLE; w.ben = 1; w.bwe = 1; w.ba = ref_a[300]; w.bd = ~ref_b[ref_a[300]];
    step(0, '0, w, "");
    idle(5);
    step(1, 11'd300, IDLE, "R4");
    idle(6);
    // R5: reset with keys in flight, contents survive
    step(1, 11'd7, IDLE, "R5");
    step(1, 11'd8, IDLE, "R5");
    step(1, 11'd9, IDLE, "R5");
    do_reset(2);
    idle(6);
    step(1, 11'd7, IDLE, "R5");
    step(1, 11'd2047, IDLE, "R5");
    step(1, 11'd200, IDLE, "R5");
    idle(7);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule